// File: doc/BRIEF.md
# Per-Processor Software Interrupt Unit

This unit sits beside one processor and gathers the interrupt sources that belong to that processor alone. It keeps a 32-bit pending word. Software can set or clear bits in it through a small register window. A per-processor timer line and a broadcast top-priority line also write into that word. The unit turns the pending word into a registered vector of priority levels for the core. Level 0 does not exist, so bit 0 of the vector is always low.

Software interrupts occupy the upper part of the pending word, bits 31..17. They appear on the level vector shifted down by sixteen positions. The timer bit (14) and the broadcast bit (15) reach the vector only while the system router's master-disable input is low.

When the router names this processor as its current target, a read of the pending word also shows the hard levels the router is steering here. Those levels are added to the read data only; the unit keeps no copy of them.

The register window accepts one request per cycle. Each request is a word offset with a valid flag. The window never applies back-pressure: `req_ready` is always high, and every request presented with `req_valid` is taken on that clock edge. A read request receives exactly one response, `rsp_valid` with `rsp_data`, on the following cycle. The response path has no ready signal, so the requester must accept it when it arrives. Writes receive no response.

Top module: `cpu_swint_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the pending word is zero, `prio_lvl_o` is all zeros and `rsp_valid` is low.
- R2: `req_ready` is always high. A read request (`req_valid` high, `req_write` low) produces `rsp_valid` high on the next cycle, and on no other cycle. At offset 0 the response carries the pending word as it stood before that edge.
- R3: A read at offset 1, 2 or 3 returns zero.
- R4: A write at offset 1 clears each pending bit whose write-data bit is 1. Only bits 31..17 and bit 15 can be cleared this way; other bits are untouched.
- R5: A write at offset 2 sets each pending bit in 31..17 whose write-data bit is 1. Bits 16..0 are not affected, so software cannot set bit 15 or bit 14.
- R6: A write whose `req_be` is not 4'b1111, or a write to offset 0 or 3, changes no state.
- R7: Pending bit 14 follows `tick_in`, sampled on each clock.
- R8: Pending bit 15 goes to 1 on a rising edge of `bcast15_in` and to 0 on a falling edge. While the input holds steady, a clear write can drop the bit. An edge of the input takes priority over a clear write in the same cycle.
- R9: Pending bits 31..17 drive `prio_lvl_o[15:1]`: bit k drives level k-16.
- R10: Pending bits 15 and 14 are ORed into levels 15 and 14 only while `route_off` is low.
- R11: While `route_sel` is high, an offset-0 read also returns `route_lvl` placed at bits 15..1. These bits are not stored: once `route_sel` is low they no longer appear.
- R12: `prio_lvl_o[0]` is always 0.
- R13: `prio_lvl_o` is registered. It changes exactly one clock after the write or input change that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Window request present |
| req_ready | output | 1 | Always high; requests are never stalled |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word offset within the window |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables; only all-ones writes take effect |
| rsp_valid | output | 1 | Read response present, one cycle after the read |
| rsp_data | output | 32 | Read response data |
| tick_in | input | 1 | Per-processor timer level |
| bcast15_in | input | 1 | Broadcast level-15 source |
| route_off | input | 1 | Router master disable; gates pending bits 15 and 14 |
| route_sel | input | 1 | This processor is the router's current target |
| route_lvl | input | 15 | Hard levels 15..1 routed here, shown on read-back |
| prio_lvl_o | output | 16 | Registered priority level vector, bit 0 always 0 |

## Verification
The assertions watch five properties on every cycle. Level 0 must stay low. While master-disable is high, the level vector must show the software bits and nothing else. Each read must get its one-cycle response, and reads at nonzero offsets must return zero. The timer bit must follow its input, and partial-byte writes must leave the software bits unchanged. Other behaviours need the bench's stimulus sequences against its reference model:
- the edge-versus-clear priority on bit 15;
- the masking of bits 15 and 14 by set and clear writes;
- hard levels appearing on read-back only while this processor is the target;
- the exact cycle on which each level line moves.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int WORD_W   = 32;
  localparam int LVL_N    = 16;
  localparam int SOFT_LO  = 17;
  localparam int SOFT_HI  = WORD_W - 1;
  localparam int SOFT_N   = SOFT_HI - SOFT_LO + 1;
  localparam int BIT_TICK = 14;
  localparam int BIT_B15  = 15;
  localparam int BE_W     = WORD_W / 8;

  typedef enum logic [1:0] {
    OFF_PEND = 2'd0,
    OFF_CLR  = 2'd1,
    OFF_SET  = 2'd2,
    OFF_NONE = 2'd3
  } win_off_e;
endpackage

// File: rtl/swint_soft_bank.sv
module swint_soft_bank
  import swint_pkg::*;
#(
  parameter int LO = SOFT_LO,
  parameter int HI = SOFT_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              set_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [HI:LO]      soft_q,
  output logic [HI:LO]      soft_d
);
  for (genvar b = LO; b <= HI; b++) begin : g_bit
    always_comb begin
      if (clr_en && wdata[b])      soft_d[b] = 1'b0;
      else if (set_en && wdata[b]) soft_d[b] = 1'b1;
      else                         soft_d[b] = soft_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_q[b] <= 1'b0;
      else        soft_q[b] <= soft_d[b];
    end
  end
endmodule

// File: rtl/swint_hw_track.sv
module swint_hw_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic bcast15_in,
  input  logic clr15,
  output logic tick_q,
  output logic tick_d,
  output logic b15_q,
  output logic b15_d
);
  logic b15_prev;

  assign tick_d = tick_in;

  always_comb begin
    if (bcast15_in && !b15_prev)      b15_d = 1'b1;
    else if (!bcast15_in && b15_prev) b15_d = 1'b0;
    else if (clr15)                   b15_d = 1'b0;
    else                              b15_d = b15_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= 1'b0;
      b15_q    <= 1'b0;
      b15_prev <= 1'b0;
    end else begin
      tick_q   <= tick_d;
      b15_q    <= b15_d;
      b15_prev <= bcast15_in;
    end
  end
endmodule

// File: rtl/swint_lvl_merge.sv
module swint_lvl_merge
  import swint_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SOFT_N-1:0]   soft_d,
  input  logic                tick_d,
  input  logic                b15_d,
  input  logic                route_off,
  output logic [LVL_N-1:0]    lvl_q
);
  logic [LVL_N-1:0] hw_part;
  logic [LVL_N-1:0] lvl_d;

  always_comb begin
    hw_part = '0;
    if (!route_off) begin
      hw_part[BIT_B15]  = b15_d;
      hw_part[BIT_TICK] = tick_d;
    end
    lvl_d = {soft_d, 1'b0} | hw_part;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/cpu_swint_unit.sv
module cpu_swint_unit
  import swint_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  input  logic [BE_W-1:0]     req_be,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_data,
  input  logic                tick_in,
  input  logic                bcast15_in,
  input  logic                route_off,
  input  logic                route_sel,
  input  logic [LVL_N-2:0]    route_lvl,
  output logic [LVL_N-1:0]    prio_lvl_o
);
  win_off_e          off;
  logic              wr_ok, clr_en, set_en, rd_req;
  logic [SOFT_HI:SOFT_LO] soft_q, soft_d;
  logic              tick_q, tick_d, b15_q, b15_d;
  logic [WORD_W-1:0] pend_word, hard_view;

  assign req_ready = 1'b1;
  assign off    = win_off_e'(req_addr);
  assign wr_ok  = req_valid && req_write && (req_be == {BE_W{1'b1}});
  assign clr_en = wr_ok && (off == OFF_CLR);
  assign set_en = wr_ok && (off == OFF_SET);
  assign rd_req = req_valid && !req_write;

  swint_soft_bank #(.LO(SOFT_LO), .HI(SOFT_HI)) u_soft (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .set_en(set_en),
    .wdata(req_wdata), .soft_q(soft_q), .soft_d(soft_d)
  );

  swint_hw_track u_hw (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bcast15_in(bcast15_in),
    .clr15(clr_en && req_wdata[BIT_B15]),
    .tick_q(tick_q), .tick_d(tick_d), .b15_q(b15_q), .b15_d(b15_d)
  );

  swint_lvl_merge u_merge (
    .clk(clk), .rst_n(rst_n), .soft_d(soft_d), .tick_d(tick_d),
    .b15_d(b15_d), .route_off(route_off), .lvl_q(prio_lvl_o)
  );

  always_comb begin
    pend_word = '0;
    pend_word[SOFT_HI:SOFT_LO] = soft_q;
    pend_word[BIT_B15]  = b15_q;
    pend_word[BIT_TICK] = tick_q;
    hard_view = '0;
    if (route_sel) hard_view[LVL_N-1:1] = route_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req)
        rsp_data <= (off == OFF_PEND) ? (pend_word | hard_view) : '0;
    end
  end
endmodule

// File: rtl/swint_chk.sv
module swint_chk
  import swint_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [1:0]             req_addr,
  input logic [WORD_W-1:0]      req_wdata,
  input logic [BE_W-1:0]        req_be,
  input logic                   rsp_valid,
  input logic [WORD_W-1:0]      rsp_data,
  input logic                   tick_in,
  input logic                   route_off,
  input logic [LVL_N-1:0]       prio_lvl_o,
  input logic [SOFT_HI:SOFT_LO] soft_q,
  input logic                   tick_q
);
  // R12
  lvl_zero_chk: assert property (@(posedge clk) prio_lvl_o[0] == 1'b0);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> (prio_lvl_o == '0 && !rsp_valid));
  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R2
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R3
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr != 2'd0) |=> rsp_data == '0);
  // R10
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(route_off) |-> prio_lvl_o[LVL_N-1:1] == soft_q);
  // R7
  tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tick_q == $past(tick_in));
  // R6
  be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_be != {BE_W{1'b1}}) |=> $stable(soft_q));
  // R5
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd2 && req_be == {BE_W{1'b1}})
    |=> (soft_q & $past(req_wdata[SOFT_HI:SOFT_LO])) == $past(req_wdata[SOFT_HI:SOFT_LO]));
endmodule

bind cpu_swint_unit swint_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_be(req_be), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .tick_in(tick_in), .route_off(route_off), .prio_lvl_o(prio_lvl_o),
  .soft_q(soft_q), .tick_q(tick_q)
);

// File: tb/test_cpu_swint_unit.sv
`timescale 1ns/1ps
module test_cpu_swint_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = 4'hF;
  logic        tick_in = 1'b0, bcast15_in = 1'b0, route_off = 1'b0, route_sel = 1'b0;
  logic [14:0] route_lvl = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [15:0] prio_lvl_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  cpu_swint_unit i_cpu_swint_unit (.*);

  always #2.5 clk = ~clk;

  // behavioural reference model
  localparam logic [31:0] SOFT_M = 32'hFFFE_0000;
  logic [31:0] m_soft, m_rd;
  logic        m_b15, m_tick, m_prev, m_rv;
  logic [15:0] m_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_soft = 0; m_b15 = 0; m_tick = 0; m_prev = 0; m_rv = 0; m_rd = 0; m_lvl = 0;
    end else begin
      logic [31:0] word;
      word = m_soft | (32'(m_b15) << 15) | (32'(m_tick) << 14);
      if (route_sel) word = word | {16'h0, route_lvl, 1'b0};
      m_rv = req_valid && !req_write;
      if (m_rv) m_rd = (req_addr == 2'd0) ? word : 32'h0;
      if (req_valid && req_write && req_be == 4'hF) begin
        if (req_addr == 2'd1) begin
          m_soft = m_soft & ~(req_wdata & SOFT_M);
          if (req_wdata[15] && (bcast15_in == m_prev)) m_b15 = 0;
        end
        if (req_addr == 2'd2) m_soft = m_soft | (req_wdata & SOFT_M);
      end
      if (bcast15_in && !m_prev) m_b15 = 1;
      if (!bcast15_in && m_prev) m_b15 = 0;
      m_prev = bcast15_in;
      m_tick = tick_in;
      m_lvl = 16'(m_soft >> 16);
      if (!route_off) m_lvl = m_lvl | (16'(m_b15) << 15) | (16'(m_tick) << 14);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, 32'(prio_lvl_o), 32'(m_lvl));   // R13 cycle-exact levels
    check("R12", 32'(prio_lvl_o[0]), 32'h0);
    check(cur_req, 32'(rsp_valid), 32'(m_rv));
    if (rsp_valid) check(cur_req, rsp_data, m_rd);
    if (rst_n) check("R2", 32'(req_ready), 32'h1);
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 4'hF;
  endtask

  task automatic rd(input logic [1:0] a);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(5);
    rst_n = 1;
    idle(2);
    rd(2'd0);
    cur_req = "R5";  wr(2'd2, 32'hFFFF_FFFF, 4'hF); rd(2'd0);
    cur_req = "R9";  idle(2);
    cur_req = "R4";  wr(2'd1, 32'h5555_FFFF, 4'hF); rd(2'd0);
    cur_req = "R6";  wr(2'd2, 32'hFFFF_0000, 4'h7); wr(2'd0, 32'hFFFF_FFFF, 4'hF);
                     wr(2'd3, 32'hFFFF_FFFF, 4'hF); wr(2'd1, 32'hFFFF_FFFF, 4'hE); rd(2'd0);
    cur_req = "R7";  tick_in = 1; idle(1); rd(2'd0); tick_in = 0; idle(1); rd(2'd0);
    cur_req = "R8";  bcast15_in = 1; idle(1); rd(2'd0);
                     wr(2'd1, 32'h0000_8000, 4'hF); rd(2'd0);
                     bcast15_in = 0; idle(1); bcast15_in = 1;
                     wr(2'd1, 32'h0000_8000, 4'hF); rd(2'd0);
                     bcast15_in = 0; idle(2);
    cur_req = "R10"; tick_in = 1; bcast15_in = 1; idle(1); route_off = 1; idle(2);
                     route_off = 0; idle(2);
                     wr(2'd1, 32'hFFFF_FFFF, 4'hF); wr(2'd2, 32'hC000_0000, 4'hF);
                     route_off = 1; idle(2); route_off = 0; idle(1);
    cur_req = "R11"; route_sel = 1; route_lvl = 15'h5A5A; rd(2'd0);
                     route_lvl = 15'h7FFF; rd(2'd0);
                     route_sel = 0; rd(2'd0);
    cur_req = "R3";  route_sel = 1; rd(2'd1); rd(2'd2); rd(2'd3); route_sel = 0;
    cur_req = "R2";  req_valid = 1; req_write = 0; req_addr = 2'd0; idle(3); req_valid = 0; idle(2);
    cur_req = "R13"; tick_in = 0; bcast15_in = 0; wr(2'd2, 32'h0002_0000, 4'hF); idle(1);
                     wr(2'd1, 32'hFFFE_0000, 4'hF); idle(2);
    cur_req = "R1";  rst_n = 0; idle(3); rst_n = 1; idle(2); rd(2'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule